// File: doc/BRIEF.md
# Single-Master Address Decoder with Local Fault Response

This block sits between one bus master and four slave ports. Each incoming request carries an address, a write flag, an access size, write data and byte strobes. The block inspects the address and size and forwards the request to exactly one slave: the boot window, the peripheral register window, instruction memory or data memory. The address, size, data and strobes reach the slave side unchanged. The selected slave's ready signal is returned to the master.

Request and response use separate valid/ready handshakes, and a slave may take any number of cycles after acceptance before it answers. The block records which slave accepted the request, so that only that slave's response reaches the master, and it accepts no new request until that response has completed. An access that hits no backed region, or that is misaligned for its size, is never forwarded. The block accepts it at once and answers one cycle later with the fault flag set.

Top module: `busdec`

## Requirements
- R1: Addresses 0x1000_0000 to 0x1000_0FFF go to slave port 1 (peripheral window), and 0x1000_1000 is unmapped.
- R2: Addresses 0x2000_0000 to 0x2000_FFFF go to port 2 (instruction memory), and 0x8000_0000 to 0x8000_FFFF go to port 3 (data memory). The words just past either region are unmapped.
- R3: Addresses 0x0000_0000 to 0x00FF_FFFF go to port 0 (boot). The remainder of the reserved aperture, 0x0100_0000 to 0x0FFF_FFFF, is unmapped.
- R4: An unmapped access raises no slave request valid and is accepted in its first cycle. One cycle after acceptance the response is valid with the fault flag at 1 and read data 0, and it completes on the master's response ready.
- R5: Size codes are 00 byte, 01 halfword, 10 word. A halfword with address bit 0 set, a word with either of address bits 1:0 set, or size code 11 is answered like R4. A byte access is aligned at any address.
- R6: Address, write flag, size, write data and byte strobes appear unchanged on the shared slave request lines while a request is forwarded.
- R7: At most one slave request valid is high, that of the decoded port. The master's request ready equals that slave's ready, so a stalled slave stalls the master.
- R8: After a request is accepted, request ready stays low and no slave request valid is raised until the response handshake completes.
- R9: The response valid, read data and fault flag come only from the slave that accepted the request. The master's response ready is passed only to that slave, and responses raised by other slaves are ignored.
- R10: A local fault response stays valid, with its flag and zero data unchanged, for as long as the master holds response ready low.
- R11: The synchronous active-high reset drops any outstanding transaction. After reset no response is valid, even if a slave holds its response valid high, and a new request is decoded at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mReqValid | input | 1 | Master request valid |
| mReqReady | output | 1 | Request accepted this cycle |
| mReqAddr | input | 32 | Byte address |
| mReqWe | input | 1 | 1 = write, 0 = read |
| mReqSize | input | 2 | 00 byte, 01 halfword, 10 word |
| mReqWdata | input | 32 | Lane-aligned write data |
| mReqWstrb | input | 4 | Byte strobes |
| mRspValid | output | 1 | Response valid to master |
| mRspReady | input | 1 | Master accepts the response |
| mRspRdata | output | 32 | Read data |
| mRspErr | output | 1 | Fault flag |
| slvReqValid | output | 4 | Per-port request valid |
| slvReqReady | input | 4 | Per-port request ready |
| slvReqAddr | output | 32 | Shared address to slaves |
| slvReqWe | output | 1 | Shared write flag |
| slvReqSize | output | 2 | Shared size |
| slvReqWdata | output | 32 | Shared write data |
| slvReqWstrb | output | 4 | Shared byte strobes |
| slvRspValid | input | 4 | Per-port response valid |
| slvRspReady | output | 4 | Per-port response ready |
| slvRspRdata | input | 128 | Per-port read data, port n at bits 32n+31:32n |
| slvRspErr | input | 4 | Per-port fault flag |

## Verification
The decode is driven with a table of addresses: the first and last word of every backed region, the first address past each region, the unbacked part of the boot aperture, and a hole between windows. Each of these is paired with byte, halfword and word sizes, at aligned and misaligned offsets. These cases show whether a region boundary is off by one, and whether alignment is checked before or after the region match. In each case a competing response is raised on a second slave, which shows whether the response is steered by the recorded owner or by the current address. Directed cases then stall a slave's ready, hold a fault response against a low master ready, and reset in the middle of a transaction.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_FAULT = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic fwdEn;     // present request to decoded slave
    logic capture;   // record owner of accepted request
    logic rspSlave;  // route owner's response to master
    logic rspLocal;  // present local fault response
  } ctlStrobe_t;

endpackage

// File: rtl/busdec_decode.sv
module busdec_decode
  import busdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_SLV = 4,
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_BASE = '0,
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_MASK = '0,
  localparam int IDX_W = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  output logic [NUM_SLV-1:0] hitVec,
  output logic [IDX_W-1:0]   selIdx,
  output logic               decErr
);

  logic misaligned;

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_region
    assign hitVec[g] =
      (addr & REGION_MASK[g*ADDR_W +: ADDR_W]) == REGION_BASE[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    selIdx = '0;
    for (int k = NUM_SLV - 1; k >= 0; k--) begin
      if (hitVec[k]) selIdx = IDX_W'(k);
    end
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = addr[0];
      SZ_WORD: misaligned = |addr[1:0];
      default: misaligned = 1'b1;
    endcase
  end

  assign decErr = misaligned || !(|hitVec);

endmodule

// File: rtl/busdec_ctrl.sv
module busdec_ctrl
  import busdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mReqValid,
  input  logic       decErr,
  input  logic       selReady,
  input  logic       ownRspValid,
  input  logic       mRspReady,
  output logic       mReqReady,
  output ctlStrobe_t strobe
);

  ctlState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    mReqReady = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (mReqValid) begin
          if (decErr) begin
            mReqReady = 1'b1;
            stateNext = ST_FAULT;
          end else begin
            strobe.fwdEn = 1'b1;
            mReqReady    = selReady;
            if (selReady) begin
              strobe.capture = 1'b1;
              stateNext      = ST_WAIT;
            end
          end
        end
      end
      ST_WAIT: begin
        strobe.rspSlave = 1'b1;
        if (ownRspValid && mRspReady) stateNext = ST_IDLE;
      end
      ST_FAULT: begin
        strobe.rspLocal = 1'b1;
        if (mRspReady) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R8
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    (mReqValid && mReqReady) |=> !mReqReady);

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.rspLocal && !mRspReady) |=> strobe.rspLocal);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!strobe.rspSlave && !strobe.rspLocal));

endmodule

// File: rtl/busdec_datapath.sv
module busdec_datapath
  import busdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_SLV = 4,
  localparam int IDX_W = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  ctlStrobe_t                strobe,
  input  logic [IDX_W-1:0]          selIdx,
  input  logic [ADDR_W-1:0]         mReqAddr,
  input  logic                      mReqWe,
  input  logic [1:0]                mReqSize,
  input  logic [DATA_W-1:0]         mReqWdata,
  input  logic [STRB_W-1:0]         mReqWstrb,
  input  logic                      mRspReady,
  output logic                      mRspValid,
  output logic [DATA_W-1:0]         mRspRdata,
  output logic                      mRspErr,
  output logic [NUM_SLV-1:0]        slvReqValid,
  input  logic [NUM_SLV-1:0]        slvReqReady,
  output logic [ADDR_W-1:0]         slvReqAddr,
  output logic                      slvReqWe,
  output logic [1:0]                slvReqSize,
  output logic [DATA_W-1:0]         slvReqWdata,
  output logic [STRB_W-1:0]         slvReqWstrb,
  input  logic [NUM_SLV-1:0]        slvRspValid,
  output logic [NUM_SLV-1:0]        slvRspReady,
  input  logic [NUM_SLV*DATA_W-1:0] slvRspRdata,
  input  logic [NUM_SLV-1:0]        slvRspErr,
  output logic                      selReady,
  output logic                      ownRspValid
);

  logic [IDX_W-1:0] owner;

  always_ff @(posedge clk) begin
    if (rst)                 owner <= '0;
    else if (strobe.capture) owner <= selIdx;
  end

  assign slvReqAddr  = mReqAddr;
  assign slvReqWe    = mReqWe;
  assign slvReqSize  = mReqSize;
  assign slvReqWdata = mReqWdata;
  assign slvReqWstrb = mReqWstrb;

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_port
    assign slvReqValid[g] = strobe.fwdEn && (selIdx == IDX_W'(g));
    assign slvRspReady[g] = strobe.rspSlave && mRspReady && (owner == IDX_W'(g));
  end

  assign selReady    = slvReqReady[selIdx];
  assign ownRspValid = slvRspValid[owner];

  always_comb begin
    mRspValid = 1'b0;
    mRspRdata = '0;
    mRspErr   = 1'b0;
    if (strobe.rspLocal) begin
      mRspValid = 1'b1;
      mRspErr   = 1'b1;
    end else if (strobe.rspSlave) begin
      mRspValid = ownRspValid;
      mRspRdata = slvRspRdata[owner*DATA_W +: DATA_W];
      mRspErr   = slvRspErr[owner];
    end
  end

  // R9
  rsp_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (mRspValid && mRspReady && !mRspErr) |->
      ($countones(slvRspReady & slvRspValid) == 1));

  // R9
  rsp_ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slvRspReady));

endmodule

// File: rtl/busdec.sv
module busdec
  import busdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NUM_SLV = 4,
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_BASE =
    {32'h8000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000},
  parameter logic [NUM_SLV*ADDR_W-1:0] REGION_MASK =
    {32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFF_F000, 32'hFF00_0000},
  localparam int IDX_W = (NUM_SLV > 1) ? $clog2(NUM_SLV) : 1,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mReqValid,
  output logic                      mReqReady,
  input  logic [ADDR_W-1:0]         mReqAddr,
  input  logic                      mReqWe,
  input  logic [1:0]                mReqSize,
  input  logic [DATA_W-1:0]         mReqWdata,
  input  logic [STRB_W-1:0]         mReqWstrb,
  output logic                      mRspValid,
  input  logic                      mRspReady,
  output logic [DATA_W-1:0]         mRspRdata,
  output logic                      mRspErr,
  output logic [NUM_SLV-1:0]        slvReqValid,
  input  logic [NUM_SLV-1:0]        slvReqReady,
  output logic [ADDR_W-1:0]         slvReqAddr,
  output logic                      slvReqWe,
  output logic [1:0]                slvReqSize,
  output logic [DATA_W-1:0]         slvReqWdata,
  output logic [STRB_W-1:0]         slvReqWstrb,
  input  logic [NUM_SLV-1:0]        slvRspValid,
  output logic [NUM_SLV-1:0]        slvRspReady,
  input  logic [NUM_SLV*DATA_W-1:0] slvRspRdata,
  input  logic [NUM_SLV-1:0]        slvRspErr
);

  logic [NUM_SLV-1:0] hitVec;
  logic [IDX_W-1:0]   selIdx;
  logic               decErr;
  logic               selReady;
  logic               ownRspValid;
  ctlStrobe_t         strobe;

  busdec_decode #(
    .ADDR_W(ADDR_W), .NUM_SLV(NUM_SLV),
    .REGION_BASE(REGION_BASE), .REGION_MASK(REGION_MASK)
  ) u_decode (
    .addr(mReqAddr), .size(mReqSize),
    .hitVec(hitVec), .selIdx(selIdx), .decErr(decErr)
  );

  busdec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mReqValid(mReqValid), .decErr(decErr),
    .selReady(selReady), .ownRspValid(ownRspValid), .mRspReady(mRspReady),
    .mReqReady(mReqReady), .strobe(strobe)
  );

  busdec_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLV(NUM_SLV)
  ) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe), .selIdx(selIdx),
    .mReqAddr(mReqAddr), .mReqWe(mReqWe), .mReqSize(mReqSize),
    .mReqWdata(mReqWdata), .mReqWstrb(mReqWstrb), .mRspReady(mRspReady),
    .mRspValid(mRspValid), .mRspRdata(mRspRdata), .mRspErr(mRspErr),
    .slvReqValid(slvReqValid), .slvReqReady(slvReqReady),
    .slvReqAddr(slvReqAddr), .slvReqWe(slvReqWe), .slvReqSize(slvReqSize),
    .slvReqWdata(slvReqWdata), .slvReqWstrb(slvReqWstrb),
    .slvRspValid(slvRspValid), .slvRspReady(slvRspReady),
    .slvRspRdata(slvRspRdata), .slvRspErr(slvRspErr),
    .selReady(selReady), .ownRspValid(ownRspValid)
  );

  // R4
  fault_local_chk: assert property (@(posedge clk) disable iff (rst)
    (mReqValid && mReqReady && decErr) |=>
      (mRspValid && mRspErr && (mRspRdata == '0)));

  // R4
  fault_noforward_chk: assert property (@(posedge clk) disable iff (rst)
    (mReqValid && decErr && !(|hitVec & 1'b0)) |-> (slvReqValid == '0));

  // R7
  stall_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (|(slvReqValid & ~slvReqReady)) |-> !mReqReady);

endmodule

// File: tb/busdec_tb.sv
`timescale 1ns/1ps
module busdec_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mReqValid = 1'b0;
  logic         mReqReady;
  logic [31:0]  mReqAddr = '0;
  logic         mReqWe = 1'b0;
  logic [1:0]   mReqSize = 2'b10;
  logic [31:0]  mReqWdata = '0;
  logic [3:0]   mReqWstrb = '0;
  logic         mRspValid;
  logic         mRspReady = 1'b0;
  logic [31:0]  mRspRdata;
  logic         mRspErr;
  logic [3:0]   slvReqValid;
  logic [3:0]   slvReqReady = 4'hF;
  logic [31:0]  slvReqAddr;
  logic         slvReqWe;
  logic [1:0]   slvReqSize;
  logic [31:0]  slvReqWdata;
  logic [3:0]   slvReqWstrb;
  logic [3:0]   slvRspValid = '0;
  logic [3:0]   slvRspReady;
  logic [127:0] slvRspRdata = '0;
  logic [3:0]   slvRspErr = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  busdec u_dut (.*);

  // {addr[31:0], size[1:0], expPort[2:0] (4 = fault), misaligned}
  localparam int NVEC = 18;
  localparam logic [37:0] VEC [NVEC] = '{
    {32'h0000_0000, 2'b10, 3'd0, 1'b0},
    {32'h00FF_FFFC, 2'b10, 3'd0, 1'b0},
    {32'h0100_0000, 2'b10, 3'd4, 1'b0},
    {32'h0FFF_FFF0, 2'b00, 3'd4, 1'b0},
    {32'h1000_0000, 2'b10, 3'd1, 1'b0},
    {32'h1000_0FFF, 2'b00, 3'd1, 1'b0},
    {32'h1000_1000, 2'b10, 3'd4, 1'b0},
    {32'h2000_0000, 2'b10, 3'd2, 1'b0},
    {32'h2000_FFFE, 2'b01, 3'd2, 1'b0},
    {32'h2001_0000, 2'b10, 3'd4, 1'b0},
    {32'h8000_0000, 2'b10, 3'd3, 1'b0},
    {32'h8000_FFFF, 2'b00, 3'd3, 1'b0},
    {32'h8001_0000, 2'b00, 3'd4, 1'b0},
    {32'h2000_0002, 2'b10, 3'd4, 1'b1},
    {32'h8000_0001, 2'b01, 3'd4, 1'b1},
    {32'h8000_0003, 2'b00, 3'd3, 1'b0},
    {32'h1000_0004, 2'b11, 3'd4, 1'b1},
    {32'h4000_0000, 2'b10, 3'd4, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic string portTag(input int p, input bit mis);
    if (p == 4) return mis ? "R5" : "R4";
    if (p == 0) return "R3";
    if (p == 1) return "R1";
    return "R2";
  endfunction

  function automatic logic [3:0] oneHot(input int p);
    return (p < 4) ? (4'b0001 << p) : 4'b0000;
  endfunction

  task automatic putReq(input logic [31:0] a, input logic [1:0] s, input logic we,
                        input logic [31:0] wd, input logic [3:0] ws);
    mReqValid = 1'b1; mReqAddr = a; mReqSize = s;
    mReqWe = we; mReqWdata = wd; mReqWstrb = ws;
  endtask

  // After acceptance: fault path or owner response path, ends at a negedge idle.
  task automatic finishFault(input string tag);
    #1;
    chk(mRspValid && mRspErr && mRspRdata == 0, tag,
        {mRspValid, mRspErr, 30'(mRspRdata)}, 32'hC000_0000);
    mRspReady = 1'b1;
    @(negedge clk);
    mRspReady = 1'b0;
    #1;
    chk(!mRspValid, tag, {31'd0, mRspValid}, 32'd0);
  endtask

  task automatic finishSlave(input int p, input int seed, input bit serr);
    int other;
    logic [31:0] want;
    other = (p + 1) % 4;
    want  = 32'hD000_0000 + 32'(p * 16 + seed);
    slvRspValid = oneHot(p) | oneHot(other);
    slvRspRdata = '0;
    slvRspRdata[p*32 +: 32]     = want;
    slvRspRdata[other*32 +: 32] = 32'hBAD0_0000 + 32'(seed);
    slvRspErr   = serr ? oneHot(p) : oneHot(other);
    mRspReady   = 1'b1;
    #1;
    // R9 owner response only
    chk(mRspValid && mRspRdata == want && mRspErr == serr, "R9", mRspRdata, want);
    chk(slvRspReady == oneHot(p), "R9", {28'd0, slvRspReady}, {28'd0, oneHot(p)});
    @(negedge clk);
    slvRspValid = '0; slvRspErr = '0; mRspReady = 1'b0;
    #1;
    chk(!mRspValid && mReqReady == 1'b0, "R9", {31'd0, mRspValid}, 32'd0);
  endtask

  task automatic runVec(input int i);
    logic [31:0] a;
    logic [1:0]  s;
    int          p;
    bit          mis;
    string       tag;
    logic [31:0] wd;
    logic [3:0]  ws;
    a   = VEC[i][37:6];
    s   = VEC[i][5:4];
    p   = int'(VEC[i][3:1]);
    mis = VEC[i][0];
    tag = portTag(p, mis);
    wd  = a ^ 32'hA5A5_5A5A;
    ws  = 4'(i + 1);
    @(negedge clk);
    putReq(a, s, i[0], wd, ws);
    #1;
    chk(slvReqValid == oneHot(p), tag, {28'd0, slvReqValid}, {28'd0, oneHot(p)});
    chk(mReqReady, tag, {31'd0, mReqReady}, 32'd1);
    if (p < 4) begin
      // R6 pass-through
      chk(slvReqAddr == a && slvReqWe == i[0] && slvReqSize == s &&
          slvReqWdata == wd && slvReqWstrb == ws, "R6", slvReqWdata, wd);
    end
    @(negedge clk);
    if (p == 4) begin
      mReqValid = 1'b0;
      finishFault(tag);
    end else begin
      putReq(32'h8000_0000, 2'b10, 1'b0, 32'h0, 4'hF);
      #1;
      // R8 no second acceptance while outstanding
      chk(!mReqReady && slvReqValid == 0, "R8", {31'd0, mReqReady}, 32'd0);
      mReqValid = 1'b0;
      finishSlave(p, i, (i % 3) == 0);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R11 reset state
    chk(!mRspValid && slvReqValid == 0 && slvRspReady == 0, "R11",
        {31'd0, mRspValid}, 32'd0);

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R7 stalled slave stalls master
    @(negedge clk);
    slvReqReady = 4'b1011;
    putReq(32'h2000_0010, 2'b10, 1'b1, 32'h1234_5678, 4'hF);
    #1;
    chk(!mReqReady && slvReqValid == 4'b0100, "R7", {31'd0, mReqReady}, 32'd0);
    @(negedge clk);
    #1;
    chk(!mReqReady && slvReqValid == 4'b0100, "R7", {28'd0, slvReqValid}, 32'h4);
    slvReqReady = 4'hF;
    #1;
    chk(mReqReady, "R7", {31'd0, mReqReady}, 32'd1);
    @(negedge clk);
    mReqValid = 1'b0;
    finishSlave(2, 7, 1'b0);

    // R10 fault response held
    @(negedge clk);
    putReq(32'h5000_0000, 2'b10, 1'b0, 32'h0, 4'hF);
    @(negedge clk);
    mReqValid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(mRspValid && mRspErr && mRspRdata == 0, "R10",
          {mRspValid, mRspErr, 30'(mRspRdata)}, 32'hC000_0000);
      @(negedge clk);
    end
    finishFault("R10");

    // R11 reset drops an outstanding transaction
    @(negedge clk);
    putReq(32'h8000_0100, 2'b10, 1'b0, 32'h0, 4'hF);
    @(negedge clk);
    mReqValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    slvRspValid = 4'b1000;
    slvRspRdata[127:96] = 32'hFACE_0001;
    mRspReady = 1'b1;
    #1;
    chk(!mRspValid && slvRspReady == 0, "R11", {31'd0, mRspValid}, 32'd0);
    slvRspValid = '0; mRspReady = 1'b0;
    putReq(32'h1000_0008, 2'b10, 1'b0, 32'h0, 4'hF);
    #1;
    chk(mReqReady && slvReqValid == 4'b0010, "R11", {28'd0, slvReqValid}, 32'h2);
    @(negedge clk);
    mReqValid = 1'b0;
    finishSlave(1, 9, 1'b0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule